// File: doc/BRIEF.md
# Processor External Interrupt Controller

This block sits next to a simple processor core and turns 32 external interrupt lines into a single redirect request. Each line sets a sticky pending bit. A mask register and a global enable register decide whether any pending bit is serviceable. When one is serviceable and the core reports an instruction boundary, the block issues a one-cycle take pulse. The pulse carries three things: the return address to store, the general register index that receives it, and the new fetch address. The new fetch address is the exception base register plus the interrupt exception ID times 32. At the same moment the enable register moves its live bit into a saved position.

Software reaches four registers through a small CSR port: pending, mask, enable and base. A write to the pending register clears every bit written as 1. A single restore input returns the saved enable bit to the live position, which models the enable handling of a return from exception.

The take decision is made by a three-state machine:

| State | Meaning |
|---|---|
| ST_IDLE | Nothing is serviceable. |
| ST_WAIT | Something is serviceable, but the core is not at an instruction boundary. |
| ST_TAKE | The single cycle in which the redirect is presented. |

Its transitions are:

- ST_IDLE goes to ST_WAIT when an interrupt is serviceable without a boundary.
- ST_IDLE or ST_WAIT goes to ST_TAKE when an interrupt is serviceable and the boundary input is high.
- ST_WAIT goes back to ST_IDLE when the interrupt stops being serviceable.
- ST_TAKE always goes to ST_IDLE.

Because the check is made again in every cycle, a line that stays pending keeps requesting until it is taken or cleared.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset, the following read as zero: pending, mask, enable and base. The take output and the line record are also 0.
- R2: A high level on line n sets pending bit n, which is visible at CSR address 0 from the next cycle. Lowering the line does not clear the bit.
- R3: The line-record output shows, one cycle later, which lines were high. A line going low clears only its own record bit.
- R4: A take happens only when all of the following hold: enable bit 0 is 1, mask AND pending is nonzero, and the boundary input is high. The take output is high for exactly the one cycle after that boundary cycle.
- R5: During the take pulse, the return address equals the core PC presented in the boundary cycle. The return register index is 30.
- R6: During the take pulse, the redirect address equals base plus 6*32, that is base + 0xC0.
- R7: When an interrupt is taken, the enable register becomes 2'b10: the saved bit 1 holds the old live bit, and the live bit 0 is cleared.
- R8: A restore pulse copies enable bit 1 into bit 0 and clears bit 1.
- R9: Writing to CSR address 0 clears each pending bit written as 1. A line that is high in the same cycle keeps its bit set.
- R10: Base register bits 7:0 always read as zero.
- R11: The CSR address map is: 0 pending, 1 mask, 2 enable (bits 1:0, upper bits read 0), 3 base. Reads are combinational.
- R12: While an interrupt is serviceable but no boundary is reported, no take occurs. The take follows the first boundary cycle.
- R13: When a take, a restore and a CSR enable write fall in the same cycle, the take wins, so enable becomes 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | External interrupt lines, level sensitive |
| insn_boundary | input | 1 | High when the core has completed an instruction |
| cur_pc | input | 32 | Current program counter of the core |
| eret_restore | input | 1 | Restores the saved enable bit |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| take | output | 1 | Single-cycle redirect pulse |
| ret_addr | output | 32 | Return address to save |
| ret_gpr | output | 5 | Index of the register that receives the return address |
| redirect_pc | output | 32 | New fetch address |
| lines_high | output | 32 | Registered record of which lines are high |

## Verification
The assertions rely on the inputs being held low during reset. They also rely on the line inputs and the CSR strobes changing only between clock edges, so that every property can relate one registered value to the cycle before it. The bench drives all inputs at the falling edge and releases reset with all lines low. It sweeps each of the 32 lines through a full set, take and restore sequence, using a base value and a PC that differ for each line. The expected vector is computed as the base with its low byte cleared, plus 0xC0.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TAKE = 2'd2
    } take_state_e;

    localparam logic [1:0] CSR_PEND = 2'd0;
    localparam logic [1:0] CSR_MASK = 2'd1;
    localparam logic [1:0] CSR_ENAB = 2'd2;
    localparam logic [1:0] CSR_BASE = 2'd3;
endpackage

// File: rtl/irq_pending_bank.sv
`timescale 1ns/1ps
module irq_pending_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] lines_high_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic pend_q;
        logic high_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                high_q <= 1'b0;
            end else begin
                // a high line always wins over a software clear
                pend_q <= lines_i[i] | (pend_q & ~clr_i[i]);
                high_q <= lines_i[i];
            end
        end

        assign pend_o[i]       = pend_q;
        assign lines_high_o[i] = high_q;
    end
endmodule

// File: rtl/irq_csr_file.sv
`timescale 1ns/1ps
module irq_csr_file
    import irq_ctrl_pkg::*;
#(
    parameter int N         = 32,
    parameter int XLEN      = 32,
    parameter int BASE_ZERO = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [1:0]      addr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            take_fire_i,
    input  logic            eret_i,
    input  logic [N-1:0]    pend_i,
    output logic [N-1:0]    mask_o,
    output logic [1:0]      en_o,
    output logic [XLEN-1:0] base_o,
    output logic [XLEN-1:0] rdata_o
);
    localparam logic [XLEN-1:0] BASE_KEEP = {XLEN{1'b1}} << BASE_ZERO;

    logic [N-1:0]    mask_q;
    logic [1:0]      en_q;
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] pend_ext;
    logic [XLEN-1:0] mask_ext;

    if (N < XLEN) begin : g_pad
        assign pend_ext = {{(XLEN-N){1'b0}}, pend_i};
        assign mask_ext = {{(XLEN-N){1'b0}}, mask_q};
    end else begin : g_full
        assign pend_ext = pend_i;
        assign mask_ext = mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (we_i) begin
            if (addr_i == CSR_MASK) mask_q <= wdata_i[N-1:0];
            if (addr_i == CSR_BASE) base_q <= wdata_i & BASE_KEEP;
        end
    end

    // enable priority: take, then restore, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)                           en_q <= 2'b00;
        else if (take_fire_i)                 en_q <= {en_q[0], 1'b0};
        else if (eret_i)                      en_q <= {1'b0, en_q[1]};
        else if (we_i && addr_i == CSR_ENAB)  en_q <= wdata_i[1:0];
    end

    always_comb begin
        unique case (addr_i)
            CSR_PEND: rdata_o = pend_ext;
            CSR_MASK: rdata_o = mask_ext;
            CSR_ENAB: rdata_o = {{(XLEN-2){1'b0}}, en_q};
            default:  rdata_o = base_q;
        endcase
    end

    assign mask_o = mask_q;
    assign en_o   = en_q;
    assign base_o = base_q;
endmodule

// File: rtl/irq_take_fsm.sv
`timescale 1ns/1ps
module irq_take_fsm
    import irq_ctrl_pkg::*;
#(
    parameter int N      = 32,
    parameter int XLEN   = 32,
    parameter int EXC_ID = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_live_i,
    input  logic [N-1:0]    pend_i,
    input  logic [N-1:0]    mask_i,
    input  logic            boundary_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [XLEN-1:0] base_i,
    output logic            take_fire_o,
    output logic            take_o,
    output logic [XLEN-1:0] ret_addr_o,
    output logic [XLEN-1:0] redirect_o
);
    localparam logic [XLEN-1:0] VEC_OFF = XLEN'(EXC_ID) << 5;

    take_state_e state_q, state_d;
    logic        serviceable;
    logic        fire;

    assign serviceable = en_live_i && (|(pend_i & mask_i));

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                if (serviceable && boundary_i) begin
                    state_d = ST_TAKE;
                    fire    = 1'b1;
                end else if (serviceable) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_TAKE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr_o <= '0;
            redirect_o <= '0;
        end else if (fire) begin
            ret_addr_o <= cur_pc_i;
            redirect_o <= base_i + VEC_OFF;
        end
    end

    assign take_fire_o = fire;
    assign take_o      = (state_q == ST_TAKE);
endmodule

// File: rtl/irq_redirect_ctrl.sv
`timescale 1ns/1ps
module irq_redirect_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N       = 32,
    parameter int XLEN    = 32,
    parameter int EXC_ID  = 6,
    parameter int RET_GPR = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    irq_lines,
    input  logic            insn_boundary,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            eret_restore,
    input  logic            csr_we,
    input  logic [1:0]      csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            take,
    output logic [XLEN-1:0] ret_addr,
    output logic [4:0]      ret_gpr,
    output logic [XLEN-1:0] redirect_pc,
    output logic [N-1:0]    lines_high
);
    logic [N-1:0]    pend_q;
    logic [N-1:0]    pend_clr;
    logic [N-1:0]    mask_q;
    logic [1:0]      en_q;
    logic [XLEN-1:0] base_q;
    logic            take_fire;

    assign pend_clr = (csr_we && csr_addr == CSR_PEND) ? csr_wdata[N-1:0] : '0;

    irq_pending_bank #(.N(N)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .lines_i      (irq_lines),
        .clr_i        (pend_clr),
        .pend_o       (pend_q),
        .lines_high_o (lines_high)
    );

    irq_csr_file #(.N(N), .XLEN(XLEN), .BASE_ZERO(8)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (csr_we),
        .addr_i      (csr_addr),
        .wdata_i     (csr_wdata),
        .take_fire_i (take_fire),
        .eret_i      (eret_restore),
        .pend_i      (pend_q),
        .mask_o      (mask_q),
        .en_o        (en_q),
        .base_o      (base_q),
        .rdata_o     (csr_rdata)
    );

    irq_take_fsm #(.N(N), .XLEN(XLEN), .EXC_ID(EXC_ID)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_live_i   (en_q[0]),
        .pend_i      (pend_q),
        .mask_i      (mask_q),
        .boundary_i  (insn_boundary),
        .cur_pc_i    (cur_pc),
        .base_i      (base_q),
        .take_fire_o (take_fire),
        .take_o      (take),
        .ret_addr_o  (ret_addr),
        .redirect_o  (redirect_pc)
    );

    assign ret_gpr = 5'(RET_GPR);
endmodule

// File: rtl/irq_redirect_ctrl_chk.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int N      = 32,
    parameter int XLEN   = 32,
    parameter int EXC_ID = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    irq_lines,
    input logic            insn_boundary,
    input logic [XLEN-1:0] cur_pc,
    input logic            csr_we,
    input logic [1:0]      csr_addr,
    input logic            take,
    input logic [XLEN-1:0] ret_addr,
    input logic [XLEN-1:0] redirect_pc,
    input logic [N-1:0]    pend,
    input logic [N-1:0]    mask,
    input logic [1:0]      en,
    input logic [XLEN-1:0] base
);
    localparam logic [XLEN-1:0] VEC_OFF = XLEN'(EXC_ID) << 5;

    assert_take_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    assert_take_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(rst_n) && $past(en[0]) && $past(insn_boundary)
                  && ($past(pend & mask) != '0)));

    assert_ret_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (ret_addr == $past(cur_pc)));

    assert_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (redirect_pc == $past(base) + VEC_OFF));

    assert_enable_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (en == 2'b10));

    assert_line_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(irq_lines)) == $past(irq_lines)));

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(csr_we) && $past(csr_addr) == CSR_PEND))
        |-> ((pend & $past(pend)) == $past(pend)));

    assert_base_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        base[7:0] == 8'h00);
endmodule

bind irq_redirect_ctrl irq_redirect_ctrl_chk #(.N(N), .XLEN(XLEN), .EXC_ID(EXC_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_lines     (irq_lines),
    .insn_boundary (insn_boundary),
    .cur_pc        (cur_pc),
    .csr_we        (csr_we),
    .csr_addr      (csr_addr),
    .take          (take),
    .ret_addr      (ret_addr),
    .redirect_pc   (redirect_pc),
    .pend          (pend_q),
    .mask          (mask_q),
    .en            (en_q),
    .base          (base_q)
);

// File: tb/irq_redirect_ctrl_tb.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_tb;
    localparam int N = 32;
    localparam int XLEN = 32;
    localparam logic [1:0] A_PEND = 2'd0, A_MASK = 2'd1, A_ENAB = 2'd2, A_BASE = 2'd3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    irq_lines;
    logic            insn_boundary;
    logic [XLEN-1:0] cur_pc;
    logic            eret_restore;
    logic            csr_we;
    logic [1:0]      csr_addr;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic            take;
    logic [XLEN-1:0] ret_addr;
    logic [4:0]      ret_gpr;
    logic [XLEN-1:0] redirect_pc;
    logic [N-1:0]    lines_high;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    irq_redirect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .insn_boundary(insn_boundary),
        .cur_pc(cur_pc), .eret_restore(eret_restore), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .take(take), .ret_addr(ret_addr),
        .ret_gpr(ret_gpr), .redirect_pc(redirect_pc), .lines_high(lines_high)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base_w, pc_v;
        rst_n = 1'b0; irq_lines = '0; insn_boundary = 1'b0; cur_pc = '0;
        eret_restore = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PEND, v); check("R1 pend", v, 0);
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_ENAB, v); check("R1 enab", v, 0);
        rd(A_BASE, v); check("R1 base", v, 0);
        check("R1 take", {31'd0, take}, 0);
        check("R1 lines", lines_high, 0);

        // R11 register map and widths, R10 base low bits
        wr(A_MASK, 32'h1234_5678); rd(A_MASK, v); check("R11 mask", v, 32'h1234_5678);
        wr(A_ENAB, 32'hFFFF_FFFC); rd(A_ENAB, v); check("R11 enab upper", v, 0);
        wr(A_BASE, 32'hFFFF_FFFF); rd(A_BASE, v); check("R10 base", v, 32'hFFFF_FF00);
        wr(A_MASK, 0);

        // R3 line record, R2 sticky
        @(negedge clk); irq_lines = 32'h0000_00A5;
        @(negedge clk); check("R3 record", lines_high, 32'h0000_00A5);
        irq_lines = 32'h0000_0085;
        @(negedge clk); check("R3 drop", lines_high, 32'h0000_0085);
        irq_lines = '0;
        @(negedge clk); check("R3 all low", lines_high, 0);
        rd(A_PEND, v); check("R2 sticky", v, 32'h0000_00A5);

        // R9 write-1-to-clear and line-wins
        wr(A_PEND, 32'h0000_0005); rd(A_PEND, v); check("R9 clear", v, 32'h0000_00A0);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = A_PEND; csr_wdata = 32'h0000_0022; irq_lines = 32'h0000_0002;
        @(negedge clk);
        csr_we = 1'b0; irq_lines = '0;
        rd(A_PEND, v); check("R9 line wins", v, 32'h0000_0082);
        wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); check("R9 clear all", v, 0);

        // R4 enable off: no take
        @(negedge clk); irq_lines = 32'h10;
        @(negedge clk); irq_lines = '0;
        wr(A_MASK, 32'h10); wr(A_ENAB, 0);
        insn_boundary = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); check("R4 enable off", {31'd0, take}, 0);
        end
        insn_boundary = 1'b0;
        // R4 mask mismatch: no take
        wr(A_MASK, 32'h08); wr(A_ENAB, 1);
        insn_boundary = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); check("R4 mask mismatch", {31'd0, take}, 0);
        end
        insn_boundary = 1'b0;

        // R12 wait without boundary, then take
        wr(A_BASE, 32'h0000_4000);
        wr(A_MASK, 32'h10);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); check("R12 no boundary", {31'd0, take}, 0);
        end
        insn_boundary = 1'b1; cur_pc = 32'h0000_0ABC;
        @(negedge clk); insn_boundary = 1'b0;
        check("R12 take", {31'd0, take}, 1);
        check("R12 ret", ret_addr, 32'h0000_0ABC);
        // R8 restore
        @(negedge clk); eret_restore = 1'b1;
        @(negedge clk); eret_restore = 1'b0;
        rd(A_ENAB, v); check("R8 restore", v, 1);
        wr(A_PEND, 32'hFFFF_FFFF);
        @(negedge clk); eret_restore = 1'b1;
        @(negedge clk); eret_restore = 1'b0;
        rd(A_ENAB, v); check("R8 restore clears", v, 0);

        // R13 take beats restore and csr write
        wr(A_ENAB, 1);
        @(negedge clk); irq_lines = 32'h10;
        @(negedge clk); irq_lines = '0;
        insn_boundary = 1'b1; eret_restore = 1'b1;
        csr_we = 1'b1; csr_addr = A_ENAB; csr_wdata = 32'h1;
        @(negedge clk);
        insn_boundary = 1'b0; eret_restore = 1'b0; csr_we = 1'b0;
        check("R13 take", {31'd0, take}, 1);
        rd(A_ENAB, v); check("R13 enab", v, 2);
        wr(A_PEND, 32'hFFFF_FFFF);

        // Sweep over every line: R2 R4 R5 R6 R7 R8
        for (int n = 0; n < N; n++) begin
            base_w = 32'h1000_0000 + (n << 12) + 32'h5A;
            pc_v   = 32'h8000_0000 + (n * 4);
            wr(A_PEND, 32'hFFFF_FFFF);
            wr(A_MASK, 32'h1 << n);
            wr(A_BASE, base_w);
            wr(A_ENAB, 1);
            irq_lines = 32'h1 << n;
            @(negedge clk); irq_lines = '0;
            rd(A_PEND, v); check("R2 set", v, 32'h1 << n);
            check("R4 no boundary", {31'd0, take}, 0);
            @(negedge clk);
            rd(A_PEND, v); check("R2 held", v, 32'h1 << n);
            insn_boundary = 1'b1; cur_pc = pc_v;
            @(negedge clk); insn_boundary = 1'b0;
            check("R4 take", {31'd0, take}, 1);
            check("R5 ret addr", ret_addr, pc_v);
            check("R5 ret gpr", {27'd0, ret_gpr}, 30);
            check("R6 vector", redirect_pc, (base_w & 32'hFFFF_FF00) + 32'd192);
            rd(A_ENAB, v); check("R7 enab", v, 2);
            @(negedge clk); check("R4 single pulse", {31'd0, take}, 0);
            eret_restore = 1'b1;
            @(negedge clk); eret_restore = 1'b0;
            rd(A_ENAB, v); check("R8 enab", v, 1);
        end

        finish_run();
    end
endmodule